// File: doc/BRIEF.md
# Synchronous Burst Static RAM

This block is a clocked static RAM with its own burst address generator. Each access is 18 bits wide and is split into two 9-bit byte lanes, and each lane has its own active-low write enable. All inputs except the output enable are captured on the rising clock edge. Two active-low start inputs load a new base address. One start input is meant for the processor and the other for a cache controller, and they differ in priority and in their read/write rules. After the load, an active-low advance input either steps the two lowest address bits through a modulo-4 binary count or holds them to insert a wait state.

Chip enable is examined only when a base address is loaded. A load with chip enable high puts the block in a deselected state, and no access takes place until the next load with chip enable low. Reads are registered: the word at the address accessed on an edge appears on `dout` from that edge until the next one. The bidirectional data bus is split into `din`, `dout` and a drive-enable output `dout_en`. `dout_en` combines a registered read flag with the unregistered, active-low output enable.

The word count is set by `ADDR_W`. `ADDR_W = 16` gives 65,536 words. The default of 10 keeps the array small when elaborated.

A controller state machine has two states. `ST_DESEL` is the reset state, and `ST_SEL` means the last load had chip enable low. It has four named transitions:
- LOAD_SEL: either start input is low and chip enable is low; the next state is `ST_SEL`.
- LOAD_DESEL: either start input is low and chip enable is high; the next state is `ST_DESEL`.
- HOLD_SEL: both start inputs are high while in `ST_SEL`; the state stays `ST_SEL`.
- HOLD_DESEL: both start inputs are high while in `ST_DESEL`; the state stays `ST_DESEL`.

Top module: `sbsram_top`

## Requirements
- R1: Reads are registered. After an edge that performs a read at address A, `dout` equals the stored word at A and keeps that value until the next edge.
- R2: An edge with `ps_start_n` low loads `addr_in` as the base address and performs a read. This happens whatever the values of `we_n` and `cc_start_n`.
- R3: A write can be started with `ps_start_n`. The first edge has `ps_start_n` low and loads the address. The next edge has both start inputs high, `adv_n` high and a write enable low, and writes the data at that same address.
- R4: An edge with `cc_start_n` low and `ps_start_n` high loads `addr_in` as the base address. It performs a write if any bit of `we_n` is low, and a read otherwise.
- R5: `ce_n` is sampled only on load edges. A load with `ce_n` high deselects the block: `dout_en` stays low and later continue edges neither write nor read. A continue edge with `ce_n` high does not stop a selected burst.
- R6: On a continue edge (both start inputs high) in the selected state with `adv_n` low, the two lowest address bits step by +1 modulo 4 before the access. The upper address bits never change. After four steps the address is back at its starting value.
- R7: On a continue edge with `adv_n` high, the address is held (a wait state). The access is still a write if any bit of `we_n` is low, and a read otherwise.
- R8: A write updates only the enabled lanes. `we_n[0]` enables bits 8:0 and `we_n[1]` enables bits 17:9.
- R9: `dout_en` is high only when the last edge performed a selected read and `oe_n` is low. It follows `oe_n` without waiting for a clock edge, and it is low after any write edge regardless of `oe_n`.
- R10: After reset the block is in `ST_DESEL` and `dout_en` is low. The burst counter is cleared to zero.
- R11: A load edge abandons a burst in progress. The next access uses the new base address and counts from its low two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| addr_in | input | ADDR_W | External base address |
| din | input | 18 | Write data |
| ce_n | input | 1 | Active-low chip enable, sampled on load edges |
| ps_start_n | input | 1 | Processor start; loads the address and forces a read |
| cc_start_n | input | 1 | Controller start; loads the address, write or read by `we_n` |
| adv_n | input | 1 | Active-low burst advance |
| we_n | input | 2 | Active-low lane write enables (bit 0 = bits 8:0) |
| oe_n | input | 1 | Active-low asynchronous output enable |
| dout | output | 18 | Registered read data |
| dout_en | output | 1 | Output drive enable for the data bus |

## Verification
The properties assume that the control inputs are stable around each rising edge. They also assume that `oe_n` is the only input that changes between edges in a way the outputs must follow.

The bench changes every synchronous input a short time after an edge. The only input it changes mid-cycle is `oe_n`, and it restores `oe_n` before the next edge.

The address-step properties assume that `ADDR_W` is at least 3, so that upper address bits exist. The bench reads only addresses it has written first, so every compared word is defined.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    // Controller state: selected after a load with chip enable low.
    typedef enum logic {
        ST_DESEL = 1'b0,
        ST_SEL   = 1'b1
    } sb_state_t;

    // Operation chosen for the current edge.
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } sb_op_t;

endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
    import sbsram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             ps_start_n,
    input  logic             cc_start_n,
    input  logic             adv_n,
    input  logic [LANES-1:0] we_n,
    output logic             load,
    output logic             step,
    output sb_op_t           op,
    output logic             sel_q
);

    sb_state_t state_q, state_nxt;
    logic      any_we;
    logic      is_load;

    assign any_we  = |(~we_n);
    assign is_load = ~ps_start_n | ~cc_start_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Transitions: LOAD_SEL, LOAD_DESEL, HOLD_SEL, HOLD_DESEL
    always_comb begin
        state_nxt = state_q;
        if (is_load) begin
            state_nxt = ce_n ? ST_DESEL : ST_SEL;
        end
    end

    // Per-edge decode
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        op   = OP_NONE;
        if (!ps_start_n) begin
            // Processor start: load, read, write enables ignored
            load = 1'b1;
            op   = ce_n ? OP_NONE : OP_RD;
        end else if (!cc_start_n) begin
            load = 1'b1;
            if (!ce_n) begin
                op = any_we ? OP_WR : OP_RD;
            end
        end else begin
            unique case (state_q)
                ST_SEL: begin
                    step = ~adv_n;
                    op   = any_we ? OP_WR : OP_RD;
                end
                ST_DESEL: begin
                    step = 1'b0;
                    op   = OP_NONE;
                end
                default: begin
                    step = 1'b0;
                    op   = OP_NONE;
                end
            endcase
        end
    end

    assign sel_q = (state_q == ST_SEL);

endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] addr_q
);

    localparam int HI_W = ADDR_W - 2;

    logic [HI_W-1:0] base_q;
    logic [1:0]      cnt_q;
    logic [1:0]      cnt_nxt;

    // Modulo-4 binary step of the two low bits only
    assign cnt_nxt  = cnt_q + {1'b0, step};
    assign acc_addr = load ? addr_in : {base_q, cnt_nxt};
    assign addr_q   = {base_q, cnt_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
        end else if (load) begin
            base_q <= addr_in[ADDR_W-1:2];
            cnt_q  <= addr_in[1:0];
        end else begin
            cnt_q  <= cnt_nxt;
        end
    end

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [LANES-1:0]        lane_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout_q
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] old_word;
    logic [DATA_W-1:0] new_word;

    assign old_word = mem[addr];

    // Lane merge: enabled lanes take din, others keep stored bits
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign new_word[g*LANE_W +: LANE_W] = lane_en[g] ? din[g*LANE_W +: LANE_W]
                                                         : old_word[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= new_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (rd_en) begin
            dout_q <= old_word;
        end
    end

endmodule

// File: rtl/sbsram_top.sv
module sbsram_top
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] din,
    input  logic              ce_n,
    input  logic              ps_start_n,
    input  logic              cc_start_n,
    input  logic              adv_n,
    input  logic [LANES-1:0]  we_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    logic              load;
    logic              step;
    sb_op_t            op;
    logic              sel_q;
    logic [ADDR_W-1:0] acc_addr;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_en;
    logic              rd_en;
    logic              rd_q;

    sbsram_ctrl #(.LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .ps_start_n (ps_start_n),
        .cc_start_n (cc_start_n),
        .adv_n      (adv_n),
        .we_n       (we_n),
        .load       (load),
        .step       (step),
        .op         (op),
        .sel_q      (sel_q)
    );

    sbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .addr_in  (addr_in),
        .acc_addr (acc_addr),
        .addr_q   (addr_q)
    );

    assign wr_en = (op == OP_WR);
    assign rd_en = (op == OP_RD);

    sbsram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .lane_en (~we_n),
        .addr    (acc_addr),
        .din     (din),
        .dout_q  (dout)
    );

    // Registered "last edge was a selected read"
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
        end else begin
            rd_q <= rd_en;
        end
    end

    assign dout_en = rd_q & ~oe_n;

endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              ps_start_n,
    input logic              cc_start_n,
    input logic              adv_n,
    input logic [LANES-1:0]  we_n,
    input logic              oe_n,
    input logic              dout_en,
    input logic              sel_q,
    input logic [ADDR_W-1:0] addr_q
);

    // R2
    ps_read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !ps_start_n && !ce_n) |-> (dout_en == !oe_n));

    // R5
    desel_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && (!ps_start_n || !cc_start_n) && ce_n) |-> !dout_en);

    // R9
    write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && ps_start_n && (we_n != '1)) |-> !dout_en);

    // R9
    oe_high_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en);

    // R6
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && ps_start_n && cc_start_n) |->
            (addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2])));

    // R6
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && sel_q && ps_start_n && cc_start_n && !adv_n) |->
            (addr_q[1:0] == 2'($past(addr_q[1:0]) + 2'd1)));

    // R7
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && ps_start_n && cc_start_n && adv_n) |-> $stable(addr_q));

endmodule

bind sbsram_top sbsram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_sbsram_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .ps_start_n (ps_start_n),
    .cc_start_n (cc_start_n),
    .adv_n      (adv_n),
    .we_n       (we_n),
    .oe_n       (oe_n),
    .dout_en    (dout_en),
    .sel_q      (sel_q),
    .addr_q     (addr_q)
);

// File: tb/tb_sbsram_top.sv
module tb_sbsram_top;

    localparam int AW = 10;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] din = '0;
    logic          ce_n = 1'b0;
    logic          ps_start_n = 1'b1;
    logic          cc_start_n = 1'b1;
    logic          adv_n = 1'b1;
    logic [1:0]    we_n = 2'b11;
    logic          oe_n = 1'b0;
    logic [DW-1:0] dout;
    logic          dout_en;

    logic [DW-1:0] ref_mem [1 << AW];
    int            nchk = 0;
    int            nerr = 0;
    bit            done = 1'b0;

    sbsram_top #(.ADDR_W(AW)) dut (
        .clk, .rst_n, .addr_in, .din, .ce_n, .ps_start_n, .cc_start_n,
        .adv_n, .we_n, .oe_n, .dout, .dout_en
    );

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] pat(int a);
        return DW'(a * 1237 + 91);
    endfunction

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_in();
        ps_start_n = 1'b1;
        cc_start_n = 1'b1;
        adv_n      = 1'b1;
        we_n       = 2'b11;
        ce_n       = 1'b0;
    endtask

    task automatic cc_read(int a);
        idle_in();
        cc_start_n = 1'b0;
        addr_in    = AW'(a);
        cyc();
        idle_in();
    endtask

    // R10: reset state
    task automatic t_reset();
        chk("R10 dout_en after reset", DW'(dout_en), DW'(0));
        adv_n = 1'b0;
        cyc();
        chk("R10 continue while deselected, no drive", DW'(dout_en), DW'(0));
        idle_in();
    endtask

    // R4/R6/R9: fill words 0..63 with controller-start write bursts
    task automatic t_fill();
        for (int b = 0; b < 16; b++) begin
            idle_in();
            cc_start_n = 1'b0;
            we_n       = 2'b00;
            addr_in    = AW'(b * 4);
            din        = pat(b * 4);
            cyc();
            ref_mem[b * 4] = pat(b * 4);
            if (b == 0) chk("R9 no drive on write edge", DW'(dout_en), DW'(0));
            cc_start_n = 1'b1;
            adv_n      = 1'b0;
            for (int k = 1; k < 4; k++) begin
                din = pat(b * 4 + k);
                cyc();
                ref_mem[b * 4 + k] = pat(b * 4 + k);
            end
        end
        idle_in();
        for (int a = 0; a < 64; a++) begin
            if (a % 4 == 0) cc_read(a);
            else begin
                adv_n = 1'b0;
                cyc();
            end
            chk("R4 R6 readback after burst write", dout, ref_mem[a]);
        end
        idle_in();
    endtask

    // R2/R6: processor-start read with write enables low, wrap from offset s
    task automatic t_wrap(int s);
        idle_in();
        ps_start_n = 1'b0;
        cc_start_n = 1'b0;
        we_n       = 2'b00;
        din        = '0;
        addr_in    = AW'(32 + s);
        cyc();
        chk("R2 processor-start read", dout, ref_mem[32 + s]);
        chk("R9 drive on read", DW'(dout_en), DW'(1));
        idle_in();
        adv_n = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            cyc();
            chk("R6 burst wrap modulo 4", dout, ref_mem[32 + ((s + k) % 4)]);
        end
        idle_in();
    endtask

    // R7: wait states in a read burst and a write wait state
    task automatic t_wait();
        cc_read(8);
        chk("R4 controller read", dout, ref_mem[8]);
        adv_n = 1'b0; cyc();
        chk("R6 step", dout, ref_mem[9]);
        adv_n = 1'b1; cyc();
        chk("R7 wait state holds address", dout, ref_mem[9]);
        cyc();
        chk("R7 second wait state", dout, ref_mem[9]);
        adv_n = 1'b0; cyc();
        chk("R7 resume after wait", dout, ref_mem[10]);
        adv_n = 1'b1; we_n = 2'b00; din = 18'h2A5A5; cyc();
        ref_mem[10] = 18'h2A5A5;
        chk("R7 write wait state no drive", DW'(dout_en), DW'(0));
        we_n = 2'b11; cyc();
        chk("R7 write landed at held address", dout, ref_mem[10]);
        idle_in();
    endtask

    // R3/R8: two-edge processor-start write, lower lane; upper lane by controller
    task automatic t_pwrite();
        idle_in();
        ps_start_n = 1'b0;
        addr_in    = AW'(20);
        cyc();
        chk("R3 first edge reads", dout, ref_mem[20]);
        ps_start_n = 1'b1;
        adv_n      = 1'b1;
        we_n       = 2'b10;
        din        = 18'h3FFFF;
        cyc();
        ref_mem[20][8:0] = 9'h1FF;
        chk("R3 second edge writes, no drive", DW'(dout_en), DW'(0));
        cc_read(20);
        chk("R3 R8 lower lane only", dout, ref_mem[20]);
        idle_in();
        cc_start_n = 1'b0;
        addr_in    = AW'(21);
        we_n       = 2'b01;
        din        = 18'h00000;
        cyc();
        ref_mem[21][17:9] = 9'h000;
        cc_read(21);
        chk("R8 upper lane only", dout, ref_mem[21]);
    endtask

    // R11: bursts interrupted by each start input
    task automatic t_interrupt();
        cc_read(40);
        adv_n = 1'b0; cyc();
        chk("R11 burst beat", dout, ref_mem[41]);
        ps_start_n = 1'b0; addr_in = AW'(50); we_n = 2'b00; cc_start_n = 1'b0;
        cyc();
        chk("R11 processor start interrupts", dout, ref_mem[50]);
        idle_in(); adv_n = 1'b0; cyc();
        chk("R11 counts from new base", dout, ref_mem[51]);
        cc_start_n = 1'b0; addr_in = AW'(6); cyc();
        chk("R11 controller start interrupts", dout, ref_mem[6]);
        idle_in(); adv_n = 1'b0; cyc();
        chk("R11 step then wrap", dout, ref_mem[7]);
        cyc();
        chk("R11 wrap within new block", dout, ref_mem[4]);
        idle_in();
    endtask

    // R5: chip enable sampled only on loads
    task automatic t_desel();
        idle_in();
        cc_start_n = 1'b0; ce_n = 1'b1; addr_in = AW'(12); cyc();
        chk("R5 deselect on controller load", DW'(dout_en), DW'(0));
        idle_in(); adv_n = 1'b0; we_n = 2'b00; din = '0;
        for (int k = 0; k < 3; k++) begin
            cyc();
            chk("R5 continue while deselected", DW'(dout_en), DW'(0));
        end
        idle_in(); ps_start_n = 1'b0; ce_n = 1'b1; addr_in = AW'(13); cyc();
        chk("R5 deselect on processor load", DW'(dout_en), DW'(0));
        cc_read(12);
        chk("R5 no write while deselected", dout, ref_mem[12]);
        for (int k = 1; k < 4; k++) begin
            adv_n = 1'b0; cyc();
            chk("R5 neighbours untouched", dout, ref_mem[12 + k]);
        end
        cc_read(0);
        adv_n = 1'b0; ce_n = 1'b1; cyc();
        chk("R5 ce ignored on continue (drive)", DW'(dout_en), DW'(1));
        chk("R5 ce ignored on continue (data)", dout, ref_mem[1]);
        idle_in();
    endtask

    // R9/R1: asynchronous output enable, data held between edges
    task automatic t_oe();
        cc_read(16);
        chk("R9 drive on", DW'(dout_en), DW'(1));
        oe_n = 1'b1; #1;
        chk("R9 oe high removes drive", DW'(dout_en), DW'(0));
        oe_n = 1'b0; #1;
        chk("R9 oe low restores drive", DW'(dout_en), DW'(1));
        chk("R1 data held until next edge", dout, ref_mem[16]);
        idle_in();
        cc_start_n = 1'b0; we_n = 2'b00; addr_in = AW'(17); din = 18'h15555; cyc();
        ref_mem[17] = 18'h15555;
        chk("R9 oe ignored on write edge", DW'(dout_en), DW'(0));
        cc_read(17);
        chk("R1 read after write", dout, ref_mem[17]);
        idle_in();
    endtask

    initial begin
        #200000;
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        t_reset();
        t_fill();
        for (int s = 0; s < 4; s++) t_wrap(s);
        t_wait();
        t_pwrite();
        t_interrupt();
        t_desel();
        t_oe();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule